// File: doc/BRIEF.md
# Guarded Data-Cache Block Write-Back Unit

This unit executes a write-back command on a small write-back data cache. It does not evict the block. The cache holds a tag, a valid bit and a dirty bit for each line, a per-set replacement pointer and the line data. A separate preload port fills and reads back this state. Normal loads, stores and refills are handled elsewhere.

A command carries three operands: a guard word, a 32-bit base address and a 7-bit two's-complement word offset. The command is carried out only if bit 0 of the guard is set. The target byte address is the base plus four times the offset.

If the target lies outside the uncached window and its line is present and dirty, the line is streamed to memory as sixteen 32-bit beats over a valid/ready port. The line stays valid, its dirty bit is cleared, and its replacement pointer is not touched. The issuing pipeline sees `stall` until the last beat has been accepted. Every carried-out command also empties the pending-prefetch queue.

Top module: `cbk_unit`

## Requirements
- R1: A command whose guard bit 0 is 0 has no effect. It raises no stall, writes no beat, keeps the prefetch queue and keeps the dirty bit.
- R2: The target address is `cmd_base + (sign-extended cmd_woff) * 4`, so the byte offset ranges from -256 to +252. The line number is address bits [31:6], the set is bits [7:6] and the tag is bits [31:8].
- R3: A command that hits a valid, dirty line writes sixteen beats. The addresses are the line base plus 0, 4, … 60, the data words are taken in order 0 to 15, and `mem_last` is high only on the sixteenth beat.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_last` hold their values.
- R5: After the last beat is accepted, the line is still valid and its dirty bit is 0. Repeating the same command then writes nothing.
- R6: A command that misses, or that hits a clean line, raises no stall and writes no beat.
- R7: A target address `a` with `nc_base <= a < nc_limit` is ignored completely: no stall, no beat, prefetch queue kept, dirty bit kept.
- R8: The replacement pointer of a set is never changed by a command.
- R9: A command whose guard is true and whose target is cacheable empties the prefetch queue, whether it hits or misses. A push in the same cycle is lost.
- R10: `stall` is low out of reset. It rises on the clock edge that accepts a write-back command and falls on the edge that accepts the last beat. Commands presented while `stall` is high are ignored.
- R11: The prefetch queue returns addresses in push order and holds PF_DEPTH (default 4) entries. A push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_guard | input | 32 | Guard word; bit 0 enables the command |
| cmd_base | input | 32 | Base byte address |
| cmd_woff | input | 7 | Signed word offset |
| stall | output | 1 | Holds the issuing pipeline during a write-back |
| nc_base | input | 32 | Uncached window start (inclusive) |
| nc_limit | input | 32 | Uncached window end (exclusive) |
| mem_valid | output | 1 | Write beat present |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Beat byte address |
| mem_data | output | 32 | Beat data |
| mem_last | output | 1 | Final beat of the line |
| pf_in_valid | input | 1 | Push a prefetch request |
| pf_in_addr | input | 32 | Prefetch address to push |
| pf_out_valid | output | 1 | Queue is non-empty |
| pf_out_addr | output | 32 | Oldest queued prefetch address |
| pf_out_ready | input | 1 | Pop the oldest entry |
| pl_we | input | 1 | Preload write strobe |
| pl_set | input | 2 | Preload / readback set |
| pl_way | input | 1 | Preload / readback way |
| pl_word | input | 4 | Preload data word index |
| pl_data | input | 32 | Preload data word |
| pl_tag | input | 24 | Preload tag |
| pl_valid | input | 1 | Preload valid bit |
| pl_dirty | input | 1 | Preload dirty bit |
| pl_lru | input | 1 | Preload replacement pointer of the set |
| pl_rd_valid | output | 1 | Readback valid bit of the addressed line |
| pl_rd_dirty | output | 1 | Readback dirty bit of the addressed line |
| pl_rd_lru | output | 1 | Readback replacement pointer of the addressed set |

## Verification
The hardest situation to reach is a second command that arrives while a write-back is stalled on back-pressure. That command must be dropped without disturbing the line it names. The bench gets there by holding `mem_ready` low right after an issue and presenting a command for another dirty line in the same set. It then lets the first burst finish and reads back the second line's dirty bit before issuing that command properly. The inclusive and exclusive edges of the uncached window are hit exactly by placing a target address equal to `nc_base` and then equal to `nc_limit`. The extreme offsets -256 and +252 are each aimed back at the same line.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BLK_BYTES  = 64;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEATS      = BLK_BYTES / BEAT_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int OFF_W      = $clog2(BLK_BYTES);
    localparam int BLK_W      = ADDR_W - OFF_W;
    localparam int WOFF_W     = 7;

    typedef enum logic {
        CB_IDLE  = 1'b0,
        CB_BURST = 1'b1
    } cb_state_e;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [BEAT_W-1:0] beat;
    } cb_job_t;

    // signed word offset -> signed byte offset
    function automatic logic [ADDR_W-1:0] woff_bytes(input logic [WOFF_W-1:0] w);
        return {{(ADDR_W-WOFF_W-2){w[WOFF_W-1]}}, w, 2'b00};
    endfunction
endpackage

// File: rtl/cbk_tagstore.sv
module cbk_tagstore #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    output logic [$clog2(WAYS)-1:0]  lk_way,
    output logic                     lk_dirty,
    input  logic                     clr_en,
    input  logic [$clog2(SETS)-1:0]  clr_set,
    input  logic [$clog2(WAYS)-1:0]  clr_way,
    input  logic                     pl_we,
    input  logic [$clog2(SETS)-1:0]  pl_set,
    input  logic [$clog2(WAYS)-1:0]  pl_way,
    input  logic [TAG_W-1:0]         pl_tag,
    input  logic                     pl_valid,
    input  logic                     pl_dirty,
    input  logic [$clog2(WAYS)-1:0]  pl_lru,
    output logic                     rb_valid,
    output logic                     rb_dirty,
    output logic [$clog2(WAYS)-1:0]  rb_lru
);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  drt_q [SETS];
    logic [WAY_W-1:0] lru_q [SETS];
    logic [WAYS-1:0]  hv;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                drt_q[s] <= '0;
                lru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            if (clr_en) drt_q[clr_set][clr_way] <= 1'b0;
            if (pl_we) begin
                tag_q[pl_set][pl_way] <= pl_tag;
                vld_q[pl_set][pl_way] <= pl_valid;
                drt_q[pl_set][pl_way] <= pl_dirty;
                lru_q[pl_set]         <= pl_lru;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hv[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign lk_hit   = |hv;
    assign lk_dirty = |(hv & drt_q[lk_set]);

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hv[w]) lk_way = WAY_W'(w);
    end

    assign rb_valid = vld_q[pl_set][pl_way];
    assign rb_dirty = drt_q[pl_set][pl_way];
    assign rb_lru   = lru_q[pl_set];
endmodule

// File: rtl/cbk_datastore.sv
module cbk_datastore import cbk_pkg::*; #(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [$clog2(SETS)-1:0] wr_set,
    input  logic [$clog2(WAYS)-1:0] wr_way,
    input  logic [BEAT_W-1:0]       wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [$clog2(SETS)-1:0] rd_set,
    input  logic [$clog2(WAYS)-1:0] rd_way,
    input  logic [BEAT_W-1:0]       rd_word,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int DEPTH = SETS * WAYS * BEATS;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign wr_idx = IDX_W'((int'(wr_set) * WAYS + int'(wr_way)) * BEATS + int'(wr_word));
    assign rd_idx = IDX_W'((int'(rd_set) * WAYS + int'(rd_way)) * BEATS + int'(rd_word));

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/cbk_pfq.sv
module cbk_pfq import cbk_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              out_ready
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] q_mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              push, pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push = in_valid && (cnt_q != CNT_W'(DEPTH));
    assign pop  = out_ready && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                q_mem[wr_q] <= in_addr;
                wr_q        <= nxt(wr_q);
            end
            if (pop) rd_q <= nxt(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out_valid = (cnt_q != '0);
    assign out_addr  = q_mem[rd_q];
endmodule

// File: rtl/cbk_unit.sv
module cbk_unit import cbk_pkg::*; #(
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int PF_DEPTH = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cmd_valid,
    input  logic [31:0]                           cmd_guard,
    input  logic [31:0]                           cmd_base,
    input  logic [6:0]                            cmd_woff,
    output logic                                  stall,
    input  logic [31:0]                           nc_base,
    input  logic [31:0]                           nc_limit,
    output logic                                  mem_valid,
    input  logic                                  mem_ready,
    output logic [31:0]                           mem_addr,
    output logic [31:0]                           mem_data,
    output logic                                  mem_last,
    input  logic                                  pf_in_valid,
    input  logic [31:0]                           pf_in_addr,
    output logic                                  pf_out_valid,
    output logic [31:0]                           pf_out_addr,
    input  logic                                  pf_out_ready,
    input  logic                                  pl_we,
    input  logic [$clog2(SETS)-1:0]               pl_set,
    input  logic [$clog2(WAYS)-1:0]               pl_way,
    input  logic [3:0]                            pl_word,
    input  logic [31:0]                           pl_data,
    input  logic [32-6-$clog2(SETS)-1:0]          pl_tag,
    input  logic                                  pl_valid,
    input  logic                                  pl_dirty,
    input  logic [$clog2(WAYS)-1:0]               pl_lru,
    output logic                                  pl_rd_valid,
    output logic                                  pl_rd_dirty,
    output logic [$clog2(WAYS)-1:0]               pl_rd_lru
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    cb_state_e          st_q;
    cb_job_t            job_q;
    logic [SET_W-1:0]   set_q;
    logic [WAY_W-1:0]   way_q;

    logic [ADDR_W-1:0]  tgt;
    logic               in_nc, issue, active, go, done;
    logic               lk_hit, lk_dirty;
    logic [WAY_W-1:0]   lk_way;

    // target address and window test, all in the issue cycle
    assign tgt    = cmd_base + woff_bytes(cmd_woff);
    assign in_nc  = (tgt >= nc_base) && (tgt < nc_limit);
    assign issue  = cmd_valid && (st_q == CB_IDLE);
    assign active = issue && cmd_guard[0] && !in_nc;
    assign go     = active && lk_hit && lk_dirty;
    assign done   = mem_valid && mem_ready && mem_last;

    cbk_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_set   (tgt[OFF_W +: SET_W]),
        .lk_tag   (tgt[ADDR_W-1 -: TAG_W]),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .lk_dirty (lk_dirty),
        .clr_en   (done),
        .clr_set  (set_q),
        .clr_way  (way_q),
        .pl_we    (pl_we),
        .pl_set   (pl_set),
        .pl_way   (pl_way),
        .pl_tag   (pl_tag),
        .pl_valid (pl_valid),
        .pl_dirty (pl_dirty),
        .pl_lru   (pl_lru),
        .rb_valid (pl_rd_valid),
        .rb_dirty (pl_rd_dirty),
        .rb_lru   (pl_rd_lru)
    );

    cbk_datastore #(.SETS(SETS), .WAYS(WAYS)) i_data (
        .clk     (clk),
        .wr_en   (pl_we),
        .wr_set  (pl_set),
        .wr_way  (pl_way),
        .wr_word (pl_word),
        .wr_data (pl_data),
        .rd_set  (set_q),
        .rd_way  (way_q),
        .rd_word (job_q.beat),
        .rd_data (mem_data)
    );

    cbk_pfq #(.DEPTH(PF_DEPTH)) i_pfq (
        .clk       (clk),
        .rst       (rst),
        .flush     (active),
        .in_valid  (pf_in_valid),
        .in_addr   (pf_in_addr),
        .out_valid (pf_out_valid),
        .out_addr  (pf_out_addr),
        .out_ready (pf_out_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CB_IDLE;
            job_q <= '0;
            set_q <= '0;
            way_q <= '0;
        end else begin
            case (st_q)
                CB_IDLE: if (go) begin
                    st_q       <= CB_BURST;
                    job_q.blk  <= tgt[ADDR_W-1:OFF_W];
                    job_q.beat <= '0;
                    set_q      <= tgt[OFF_W +: SET_W];
                    way_q      <= lk_way;
                end
                CB_BURST: if (mem_ready) begin
                    if (mem_last) st_q <= CB_IDLE;
                    else          job_q.beat <= job_q.beat + 1'b1;
                end
                default: st_q <= CB_IDLE;
            endcase
        end
    end

    assign stall     = (st_q != CB_IDLE);
    assign mem_valid = (st_q == CB_BURST);
    assign mem_addr  = {job_q.blk, job_q.beat, 2'b00};
    assign mem_last  = (job_q.beat == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/cbk_checker.sv
module cbk_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [31:0] cmd_guard,
    input logic [31:0] cmd_base,
    input logic [6:0]  cmd_woff,
    input logic        stall,
    input logic [31:0] nc_base,
    input logic [31:0] nc_limit,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_data,
    input logic        mem_last,
    input logic        pf_out_valid
);
    logic [31:0] c_tgt;
    logic        c_nc;
    assign c_tgt = cmd_base + {{23{cmd_woff[6]}}, cmd_woff, 2'b00};
    assign c_nc  = (c_tgt >= nc_base) && (c_tgt < nc_limit);

    p_guard_skip_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !stall && !cmd_guard[0]) |=> !stall);

    p_beat_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    p_hold_beat_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_last)));

    p_window_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !stall && c_nc) |=> !stall);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !stall && cmd_guard[0] && !c_nc) |=> !pf_out_valid);

    p_write_stalls_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> stall);

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_last) |=> (!stall && !mem_valid));
endmodule

bind cbk_unit cbk_checker i_cbk_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_guard    (cmd_guard),
    .cmd_base     (cmd_base),
    .cmd_woff     (cmd_woff),
    .stall        (stall),
    .nc_base      (nc_base),
    .nc_limit     (nc_limit),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .mem_last     (mem_last),
    .pf_out_valid (pf_out_valid)
);

// File: tb/test_cbk_unit.sv
module test_cbk_unit;
    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_valid = 0;
    logic [31:0] cmd_guard = 0, cmd_base = 0;
    logic [6:0]  cmd_woff = 0;
    logic        stall;
    logic [31:0] nc_base = 0, nc_limit = 0;
    logic        mem_valid, mem_ready = 0, mem_last;
    logic [31:0] mem_addr, mem_data;
    logic        pf_in_valid = 0, pf_out_valid, pf_out_ready = 0;
    logic [31:0] pf_in_addr = 0, pf_out_addr;
    logic        pl_we = 0, pl_valid = 0, pl_dirty = 0;
    logic [1:0]  pl_set = 0;
    logic        pl_way = 0, pl_lru = 0;
    logic [3:0]  pl_word = 0;
    logic [31:0] pl_data = 0;
    logic [23:0] pl_tag = 0;
    logic        pl_rd_valid, pl_rd_dirty, pl_rd_lru;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cbk_unit i_cbk_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_guard(cmd_guard),
        .cmd_base(cmd_base), .cmd_woff(cmd_woff), .stall(stall),
        .nc_base(nc_base), .nc_limit(nc_limit), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_last(mem_last), .pf_in_valid(pf_in_valid), .pf_in_addr(pf_in_addr),
        .pf_out_valid(pf_out_valid), .pf_out_addr(pf_out_addr),
        .pf_out_ready(pf_out_ready), .pl_we(pl_we), .pl_set(pl_set),
        .pl_way(pl_way), .pl_word(pl_word), .pl_data(pl_data), .pl_tag(pl_tag),
        .pl_valid(pl_valid), .pl_dirty(pl_dirty), .pl_lru(pl_lru),
        .pl_rd_valid(pl_rd_valid), .pl_rd_dirty(pl_rd_dirty), .pl_rd_lru(pl_rd_lru)
    );

    function automatic logic [31:0] pat(int s, int w, int k);
        return 32'hC0DE0000 ^ (32'(s) << 12) ^ (32'(w) << 8) ^ 32'(k);
    endfunction

    function automatic logic [31:0] blk_of(logic [23:0] tag, int s);
        return {tag, 2'(s), 6'd0};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic preload(int s, int w, logic [23:0] tag, bit v, bit d, bit lru);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            pl_we = 1; pl_set = 2'(s); pl_way = 1'(w); pl_word = 4'(k);
            pl_data = pat(s, w, k); pl_tag = tag; pl_valid = v; pl_dirty = d; pl_lru = lru;
        end
        @(negedge clk);
        pl_we = 0;
    endtask

    task automatic readback(int s, int w);
        pl_set = 2'(s); pl_way = 1'(w);
        #1;
    endtask

    // ends at the negedge after the issue edge
    task automatic issue(logic [31:0] guard, logic [31:0] base, logic [6:0] woff);
        @(negedge clk);
        cmd_valid = 1; cmd_guard = guard; cmd_base = base; cmd_woff = woff;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic push_pf(logic [31:0] a);
        @(negedge clk);
        pf_in_valid = 1; pf_in_addr = a;
        @(negedge clk);
        pf_in_valid = 0;
    endtask

    task automatic pop_pf(logic [31:0] exp, string req);
        check(pf_out_valid == 1'b1, req, "pf_out_valid", 32'(pf_out_valid), 1);
        check(pf_out_addr == exp, req, "pf_out_addr", pf_out_addr, exp);
        pf_out_ready = 1;
        @(negedge clk);
        pf_out_ready = 0;
    endtask

    task automatic expect_idle(string req, string what);
        #1;
        check(stall == 1'b0, req, {what, " stall"}, 32'(stall), 0);
        check(mem_valid == 1'b0, req, {what, " mem_valid"}, 32'(mem_valid), 0);
    endtask

    // R3 R4 R10: consume one line burst, gap>0 drops ready every gap-th cycle
    task automatic run_burst(logic [31:0] blk, int s, int w, int gap, string req);
        int beats = 0;
        int cyc = 0;
        while (beats < 16 && cyc < 400) begin
            mem_ready = (gap == 0) ? 1'b1 : ((cyc % gap) != 0);
            #1;
            check(stall == 1'b1, "R10", "stall during burst", 32'(stall), 1);
            if (mem_valid) begin
                check(mem_addr == blk + 32'(beats * 4), req, "beat addr", mem_addr, blk + 32'(beats * 4));
                check(mem_data == pat(s, w, beats), req, "beat data", mem_data, pat(s, w, beats));
                check(mem_last == (beats == 15), req, "beat last", 32'(mem_last), 32'(beats == 15));
                if (mem_ready) beats++;
            end else begin
                check(1'b0, req, "mem_valid", 0, 1);
            end
            @(negedge clk);
            cyc++;
        end
        mem_ready = 0;
        check(beats == 16, req, "beat count", 32'(beats), 16);
        expect_idle("R10", "after burst");
    endtask

    task automatic t_reset();
        #1;
        check(stall == 1'b0, "R10", "reset stall", 32'(stall), 0);
        check(mem_valid == 1'b0, "R10", "reset mem_valid", 32'(mem_valid), 0);
        check(pf_out_valid == 1'b0, "R11", "reset queue", 32'(pf_out_valid), 0);
    endtask

    task automatic t_hit_dirty();
        logic [31:0] b = blk_of(24'h001234, 1);
        preload(1, 0, 24'h001234, 1, 1, 1);
        issue(32'h1, b + 32'h20, 7'h04);
        run_burst(b, 1, 0, 0, "R3");
        readback(1, 0);
        check(pl_rd_valid == 1'b1, "R5", "valid kept", 32'(pl_rd_valid), 1);
        check(pl_rd_dirty == 1'b0, "R5", "dirty cleared", 32'(pl_rd_dirty), 0);
        check(pl_rd_lru == 1'b1, "R8", "lru kept", 32'(pl_rd_lru), 1);
        issue(32'h1, b + 32'h20, 7'h04);
        expect_idle("R5", "reissue clean");
    endtask

    task automatic t_backpressure();
        logic [31:0] b = blk_of(24'h00ABCD, 2);
        preload(2, 1, 24'h00ABCD, 1, 1, 0);
        issue(32'h1, b + 32'h44, 7'h70);
        run_burst(b, 2, 1, 3, "R4");
        readback(2, 1);
        check(pl_rd_lru == 1'b0, "R8", "lru kept", 32'(pl_rd_lru), 0);
    endtask

    task automatic t_offset_edges();
        logic [31:0] b = blk_of(24'h000777, 0);
        preload(0, 1, 24'h000777, 1, 1, 1);
        issue(32'h1, b + 32'h100, 7'h40);
        run_burst(b, 0, 1, 0, "R2");
        preload(0, 1, 24'h000777, 1, 1, 1);
        issue(32'h1, b - 32'hFC, 7'h3F);
        run_burst(b, 0, 1, 0, "R2");
    endtask

    task automatic t_guard();
        logic [31:0] b = blk_of(24'h00F00F, 3);
        preload(3, 0, 24'h00F00F, 1, 1, 0);
        push_pf(32'h1111_0000);
        issue(32'hFFFF_FFFE, b, 7'h00);
        expect_idle("R1", "guard false");
        check(pf_out_valid == 1'b1, "R1", "queue kept", 32'(pf_out_valid), 1);
        readback(3, 0);
        check(pl_rd_dirty == 1'b1, "R1", "dirty kept", 32'(pl_rd_dirty), 1);
        issue(32'h8000_0001, b, 7'h00);
        check(pf_out_valid == 1'b0, "R9", "queue flushed on hit", 32'(pf_out_valid), 0);
        run_burst(b, 3, 0, 0, "R3");
    endtask

    task automatic t_clean_miss();
        preload(0, 0, 24'h000100, 1, 0, 0);
        issue(32'h1, blk_of(24'h000100, 0) + 32'h8, 7'h00);
        expect_idle("R6", "clean hit");
        push_pf(32'h2222_0000);
        issue(32'h1, blk_of(24'h000999, 0), 7'h00);
        expect_idle("R6", "miss");
        check(pf_out_valid == 1'b0, "R9", "queue flushed on miss", 32'(pf_out_valid), 0);
    endtask

    task automatic t_window();
        logic [31:0] b = blk_of(24'h004400, 1);
        preload(1, 1, 24'h004400, 1, 1, 0);
        push_pf(32'h3333_0000);
        nc_base = b; nc_limit = b + 32'h40;
        issue(32'h1, b, 7'h00);
        expect_idle("R7", "base inclusive");
        check(pf_out_valid == 1'b1, "R7", "queue kept", 32'(pf_out_valid), 1);
        readback(1, 1);
        check(pl_rd_dirty == 1'b1, "R7", "dirty kept", 32'(pl_rd_dirty), 1);
        nc_base = b - 32'h40; nc_limit = b;
        issue(32'h1, b, 7'h00);
        run_burst(b, 1, 1, 0, "R7");
        check(pf_out_valid == 1'b0, "R9", "queue flushed", 32'(pf_out_valid), 0);
        nc_base = 0; nc_limit = 0;
    endtask

    task automatic t_busy();
        logic [31:0] a = blk_of(24'h00F00F, 3);
        logic [31:0] b = blk_of(24'h00BEEF, 3);
        preload(3, 0, 24'h00F00F, 1, 1, 0);
        preload(3, 1, 24'h00BEEF, 1, 1, 0);
        issue(32'h1, a, 7'h00);
        mem_ready = 0;
        cmd_valid = 1; cmd_guard = 32'h1; cmd_base = b; cmd_woff = 7'h00;
        @(negedge clk);
        cmd_valid = 0;
        run_burst(a, 3, 0, 0, "R10");
        readback(3, 1);
        check(pl_rd_dirty == 1'b1, "R10", "ignored cmd kept dirty", 32'(pl_rd_dirty), 1);
        issue(32'h1, b + 32'h3C, 7'h00);
        run_burst(b, 3, 1, 2, "R3");
    endtask

    task automatic t_queue();
        for (int i = 0; i < 5; i++) push_pf(32'hA000_0000 + 32'(i * 16));
        for (int i = 0; i < 4; i++) pop_pf(32'hA000_0000 + 32'(i * 16), "R11");
        #1;
        check(pf_out_valid == 1'b0, "R11", "fifth push dropped", 32'(pf_out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_hit_dirty();
        t_backpressure();
        t_offset_edges();
        t_guard();
        t_clean_miss();
        t_window();
        t_busy();
        t_queue();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule